// File: doc/BRIEF.md
# External Access Wait-State Stretcher

This block lengthens every access to the external address space by a programmable number of clock cycles. A small control register sets a 3-bit stretch field and an enable for an external wait input. When the wait input is enabled, an access can be held beyond its programmed minimum for as long as the external device keeps that input asserted. The bus controller pulses a start strobe for each external access. It then watches `busy` to know when the access is being stretched and `acc_done` to know when it ends.

Stretching only happens in the two expanded operating modes. In every other mode, an access completes without extra cycles and the wait input has no effect. The stretch count and the wait-enable are captured when an access starts, so register writes made during an access affect only later accesses. The wait input passes through a synchronizer before the block uses it. The minimum stretch count with wait enabled covers that synchronizer's latency.

Top module: `xacc_stretcher`

## Requirements
- R1: The control register keeps bit 7 as the wait-enable and bits 2..0 as the stretch field. Bits 6..3 always read as zero. A write may happen in any cycle, and `reg_rdata` shows the new value from the next cycle.
- R2: After reset, `reg_rdata` is 0x07, `busy` is low and `acc_done` is low.
- R3: The expanded modes are `mode` = 2'b01 and 2'b10. In these modes, a strobe sampled while idle starts an access. `busy` is high from the next cycle for N cycles, where N = field + 1 when wait-enable is 0 (1 to 8 cycles).
- R4: With wait-enable 1, N is field + 1 but never less than 2. Fields 000 and 001 both give 2.
- R5: With wait-enable 1, the access continues past N for as long as the synchronized wait input is high. It ends in the first cycle at or after N in which the synchronized wait input is low. The wait input passes two flops, so the access lasts max(N, r+3) cycles if wait is high before the strobe and falls during cycle r+1.
- R6: With wait-enable 0, the wait input has no effect on the length of an access.
- R7: In modes 2'b00 and 2'b11, `busy` never rises and the wait input is ignored. A strobe gives one `acc_done` pulse in the next cycle.
- R8: A strobe that arrives while `busy` is high is dropped, not queued. No second access follows it.
- R9: Each access gives exactly one `acc_done` pulse. In the expanded modes it falls on the last cycle in which `busy` is high.
- R10: The stretch field and wait-enable are captured at the start of an access. A register write during an access does not change that access's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| mode | input | 2 | Operating mode (01, 10 expanded) |
| acc_start | input | 1 | External access start strobe |
| ext_wait | input | 1 | Asynchronous external wait, high holds the access |
| busy | output | 1 | Access is being stretched |
| acc_done | output | 1 | One-cycle access completion pulse |

## Verification
A wrong count load or a wrong decrement shows up as a `busy` window that is too long or too short. It is visible on the very access that uses the bad value, and `acc_done` lands on the wrong cycle. A stuck or extra synchronizer stage moves the end of a held access by whole cycles compared with max(N, r+3). This is visible when the release cycle is swept against the programmed minimum. A bad config capture or a missing hold-off appears within one access, either as a length that follows a mid-access write or as a second `busy` window after a held strobe.

// File: rtl/xacc_stretch_pkg.sv
package xacc_stretch_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE   = 2'b00,
      MODE_NORM_EXP = 2'b01,
      MODE_EMUL_EXP = 2'b10,
      MODE_SPECIAL  = 2'b11
   } op_mode_e;

   function automatic logic mode_allows_stretch(input logic [1:0] m);
      return (m == MODE_NORM_EXP) || (m == MODE_EMUL_EXP);
   endfunction

endpackage

// File: rtl/xacc_ctl_reg.sv
module xacc_ctl_reg #(
   parameter int unsigned REG_W   = 8,
   parameter int unsigned FIELD_W = 3,
   parameter int unsigned WEN_BIT = 7,
   parameter logic [REG_W-1:0] RESET_VAL = 8'h07
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wdata,
   output logic [REG_W-1:0]   rdata,
   output logic [FIELD_W-1:0] field,
   output logic               wait_en
);
   localparam int unsigned MASK_I = (1 << WEN_BIT) | ((1 << FIELD_W) - 1);
   localparam logic [REG_W-1:0] WR_MASK = MASK_I[REG_W-1:0];

   logic [REG_W-1:0] ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= RESET_VAL & WR_MASK;
      else if (wr_en)
         ctl_q <= wdata & WR_MASK;
   end

   assign rdata   = ctl_q;
   assign field   = ctl_q[FIELD_W-1:0];
   assign wait_en = ctl_q[WEN_BIT];

endmodule

// File: rtl/xacc_wait_sync.sv
module xacc_wait_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/xacc_stretch_cnt.sv
module xacc_stretch_cnt #(
   parameter int unsigned FIELD_W  = 3,
   parameter int unsigned MIN_WAIT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               active,
   input  logic [FIELD_W-1:0] field,
   input  logic               wait_en,
   input  logic               wait_sync,
   output logic               busy,
   output logic               done
);
   localparam int unsigned FULL  = 2 ** FIELD_W;
   localparam int unsigned MAXN  = (FULL > MIN_WAIT) ? FULL : MIN_WAIT;
   localparam int unsigned CNT_W = $clog2(MAXN + 1);

   logic [CNT_W-1:0] base_n, load_n, cnt_q;
   logic             busy_q, wen_q, pass_q, hold;

   always_comb begin
      base_n = CNT_W'(field) + CNT_W'(1);
      load_n = base_n;
      if (wait_en && (base_n < CNT_W'(MIN_WAIT)))
         load_n = CNT_W'(MIN_WAIT);
   end

   assign hold = wen_q && wait_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         wen_q  <= 1'b0;
         pass_q <= 1'b0;
      end else begin
         pass_q <= start && !active && !busy_q;
         if (!busy_q) begin
            if (start && active) begin
               busy_q <= 1'b1;
               cnt_q  <= load_n - CNT_W'(1);
               wen_q  <= wait_en;
            end
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end else if (!hold) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign done = (busy_q && (cnt_q == '0) && !hold) || pass_q;

endmodule

// File: rtl/xacc_stretcher.sv
module xacc_stretcher #(
   parameter int unsigned REG_W       = 8,
   parameter int unsigned FIELD_W     = 3,
   parameter int unsigned WEN_BIT     = 7,
   parameter logic [REG_W-1:0] RESET_VAL = 8'h07,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_WAIT    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic [1:0]       mode,
   input  logic             acc_start,
   input  logic             ext_wait,
   output logic             busy,
   output logic             acc_done
);
   import xacc_stretch_pkg::*;

   generate
      if (WEN_BIT >= REG_W || WEN_BIT < FIELD_W) begin : g_bad_bit
         $error("wait-enable bit must sit above the field and inside the register");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("synchronizer needs at least one stage");
      end
      if (MIN_WAIT < SYNC_STAGES) begin : g_bad_min
         $error("minimum wait stretch must cover synchronizer latency");
      end
   endgenerate

   logic [FIELD_W-1:0] field;
   logic               wait_en, wait_sync, active;

   assign active = mode_allows_stretch(mode);

   xacc_ctl_reg #(
      .REG_W(REG_W), .FIELD_W(FIELD_W), .WEN_BIT(WEN_BIT), .RESET_VAL(RESET_VAL)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
      .rdata(reg_rdata), .field(field), .wait_en(wait_en)
   );

   xacc_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_wait && active), .dout(wait_sync)
   );

   xacc_stretch_cnt #(.FIELD_W(FIELD_W), .MIN_WAIT(MIN_WAIT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(acc_start), .active(active),
      .field(field), .wait_en(wait_en), .wait_sync(wait_sync),
      .busy(busy), .done(acc_done)
   );

endmodule

// File: rtl/xacc_stretch_chk.sv
module xacc_stretch_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_start,
   input logic       acc_done,
   input logic       busy,
   input logic [7:0] reg_rdata
);
   // R1
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[6:3] == 4'b0000);

   // R3
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(acc_start));

   // R9
   single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done |=> !acc_done);

   // R9
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_done && busy) |=> !busy);

   // R8
   no_early_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !acc_done) |=> busy);

endmodule

bind xacc_stretcher xacc_stretch_chk u_chk (
   .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_done(acc_done),
   .busy(busy), .reg_rdata(reg_rdata)
);

// File: tb/sim_xacc_stretcher.sv
module sim_xacc_stretcher;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [1:0] mode = 2'b01;
   logic       acc_start = 1'b0;
   logic       ext_wait = 1'b0;
   logic       busy, acc_done;

   int nchk = 0;
   int nerr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xacc_stretcher u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .mode(mode), .acc_start(acc_start),
      .ext_wait(ext_wait), .busy(busy), .acc_done(acc_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] v);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // rel < 0: ext_wait left unchanged; otherwise dropped in cycle rel+1
   task automatic run_access(input int rel, input bit hold_start,
                             output int len, output int ndone, output int done_at);
      len = 0; ndone = 0; done_at = -1;
      @(negedge clk);
      acc_start = 1'b1;
      @(negedge clk);
      if (!hold_start) acc_start = 1'b0;
      for (int j = 1; j < 64; j++) begin
         if (busy) len = j;
         if (acc_done) begin ndone++; done_at = j; end
         if (j == rel + 1) ext_wait = 1'b0;
         if (!busy) break;
         @(negedge clk);
      end
      acc_start = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      int len, nd, dat, expn;
      idle(2);
      rst_n = 1'b1;
      @(negedge clk);
      // R2
      chk("R2 reset value", int'(reg_rdata), 7);
      chk("R2 busy idle", int'(busy), 0);
      chk("R2 done idle", int'(acc_done), 0);

      // R1 full sweep of write values
      for (int v = 0; v < 256; v++) begin
         wr_reg(v[7:0]);
         chk("R1 readback", int'(reg_rdata), v & 8'h87);
      end

      // R3 R4 R7 R9 sweep: mode x wait-enable x field, wait input low
      for (int m = 0; m < 4; m++)
         for (int w = 0; w < 2; w++)
            for (int f = 0; f < 8; f++) begin
               bit act;
               wr_reg(8'((w << 7) | f));
               mode = m[1:0];
               act = (m == 1) || (m == 2);
               run_access(-1, 1'b0, len, nd, dat);
               if (!act) begin
                  chk("R7 no busy in other mode", len, 0);
                  chk("R7 done next cycle", dat, 1);
               end else begin
                  expn = (w == 1 && f < 1) ? 2 : f + 1;
                  if (w == 1) chk("R4 length with wait enabled", len, expn);
                  else        chk("R3 length", len, expn);
                  chk("R9 done on last busy cycle", dat, len);
               end
               chk("R9 one done per access", nd, 1);
               idle(1);
            end

      // R6 wait ignored when disabled
      mode = 2'b10;
      for (int f = 0; f < 8; f += 3) begin
         wr_reg(8'(f));
         ext_wait = 1'b1;
         idle(3);
         run_access(-1, 1'b0, len, nd, dat);
         chk("R6 wait ignored", len, f + 1);
         ext_wait = 1'b0;
         idle(3);
      end

      // R7 wait ignored in other mode
      mode = 2'b11;
      wr_reg(8'h80);
      ext_wait = 1'b1;
      idle(3);
      run_access(-1, 1'b0, len, nd, dat);
      chk("R7 wait ignored, busy", len, 0);
      chk("R7 wait ignored, done", nd, 1);
      ext_wait = 1'b0;
      idle(3);

      // R5 release sweep
      mode = 2'b01;
      for (int k = 0; k < 3; k++) begin
         int f, n;
         f = (k == 0) ? 0 : (k == 1) ? 3 : 7;
         n = (f + 1 < 2) ? 2 : f + 1;
         wr_reg(8'(8'h80 | f));
         for (int r = 0; r <= 10; r++) begin
            ext_wait = 1'b1;
            idle(3);
            run_access(r, 1'b0, len, nd, dat);
            expn = (n > r + 3) ? n : r + 3;
            chk("R5 held length", len, expn);
            chk("R9 held done position", dat, expn);
            ext_wait = 1'b0;
            idle(3);
         end
      end

      // R8 strobe held through an access
      wr_reg(8'h03);
      run_access(-1, 1'b1, len, nd, dat);
      chk("R8 length with held strobe", len, 4);
      chk("R8 single done", nd, 1);
      @(negedge clk);
      chk("R8 not queued", int'(busy), 0);
      idle(2);

      // R10 write during an access
      wr_reg(8'h07);
      @(negedge clk);
      acc_start = 1'b1;
      @(negedge clk);
      acc_start = 1'b0;
      reg_wr_en = 1'b1;
      reg_wdata = 8'h00;
      len = busy ? 1 : 0;
      @(negedge clk);
      reg_wr_en = 1'b0;
      for (int j = 2; j < 40; j++) begin
         if (busy) len = j;
         if (!busy) break;
         @(negedge clk);
      end
      chk("R10 config captured at start", len, 8);
      chk("R10 write took effect", int'(reg_rdata), 0);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule